// File: doc/BRIEF.md
# Two-Stage I2C Clock-Enable Divider

This block turns a fast reference clock into the timing base of an I2C master. Two prescalers sit in series. The first counts reference cycles up to a programmable limit A. The second counts the first stage's wrap-arounds up to a programmable limit B. When both stages reach their limits together, the block raises a clock-enable strobe for one reference cycle. The rest of the master uses this strobe to sample the incoming SCL and SDA lines. The strobe rate is fref / ((A+1)*(B+1)).

The strobe also drives a fixed sequencer of 22 phases that produces the outgoing SCL level. SCL is driven low for 11 strobe ticks and then released high for 11 ticks, so SCL = fref / (22*(A+1)*(B+1)). The sequencer also gives single-cycle pulses that mark each SCL rising and falling edge. The transfer engine starts and stops the timing with an enable input. While the enable is low, everything is held cleared and SCL idles high. Rewriting either divider field restarts the prescalers from zero, so a counter can never sit above a freshly lowered limit.

Top module: `scl_clk_gen`

## Requirements
- R1: With the enable high and the fields steady, `sampleStrobe` repeats every (A+1)*(B+1) reference cycles. A is the 2-bit `divA` (0..3) and B is the 6-bit `divB` (0..63). Each pulse is one cycle wide, except when A=B=0: then the strobe stays high on every cycle.
- R2: One SCL period lasts exactly 22*(A+1)*(B+1) reference cycles, and exactly 22 strobe pulses fall inside one period.
- R3: Within each period, `sclOut` is low for 11*(A+1)*(B+1) cycles (11 strobe ticks) and high for the remaining 11 ticks.
- R4: After `engineEn` rises, the first strobe appears in the (A+1)*(B+1)-th cycle. SCL falls in the cycle after that strobe.
- R5: After reset, and from the cycle after `engineEn` is sampled low, `sclOut` is 1 and `sampleStrobe`, `sclRiseStb` and `sclFallStb` are 0. The phase sequencer restarts at its low half on the next enable.
- R6: When `divA` or `divB` changes while running, both prescalers restart from zero. No strobe appears in the cycle after the change. The next strobe appears (A'+1)*(B'+1)+1 cycles after the change is applied, where A' and B' are the new field values.
- R7: `sclRiseStb` is high only in the first cycle of each SCL high level, and `sclFallStb` only in the first cycle of each low level. Each pulse is one cycle wide, and the two never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| engineEn | input | 1 | Run enable from the transfer engine; low clears and idles |
| divA | input | 2 | First-stage divider field A (divide by A+1) |
| divB | input | 6 | Second-stage divider field B (divide by B+1) |
| sampleStrobe | output | 1 | One-cycle clock-enable strobe |
| sclOut | output | 1 | Outgoing SCL level (1 = released high) |
| sclRiseStb | output | 1 | Pulse in the first cycle SCL is high |
| sclFallStb | output | 1 | Pulse in the first cycle SCL is low |

## Verification
The bound and single-pulse assertions assume one thing about the inputs: a divider field only differs from its stored copy in the cycle where the restart logic clears the counters. They do not assume the fields stay constant. The stimulus changes the fields only at falling clock edges. It changes them either while the enable is low or as a single deliberate rewrite in mid-run. `engineEn` toggles freely, including in the middle of an SCL low phase. The expected periods, low times and first-strobe latencies are all computed from (A+1)*(B+1). This is done over every A value and a spread of B values that includes 0 and 63.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

  // Commands from the control to the datapath.
  typedef struct packed {
    logic clearPre;    // clear both prescaler counters
    logic stepB;       // advance the second prescaler
    logic clearPhase;  // return sequencer to phase 0
    logic stepPhase;   // advance sequencer by one tick
  } divCmd_t;

  // Status flags from the datapath back to the control.
  typedef struct packed {
    logic aTerm;       // first prescaler at its limit
    logic bTerm;       // second prescaler at its limit
    logic phaseZero;   // sequencer at the first low tick
    logic phaseHalf;   // sequencer at the first high tick
    logic phaseUpper;  // sequencer in the high half
  } divStat_t;

endpackage

// File: rtl/scl_div_counter.sv
module scl_div_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         term
);

  assign term = (cnt == limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= term ? '0 : cnt + W'(1);
    end
  end

  // Count never exceeds its limit unless a clear is in progress.
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    !clear |-> (cnt <= limit)); // R1

endmodule

// File: rtl/scl_div_datapath.sv
module scl_div_datapath
  import scl_div_pkg::*;
#(
  parameter int DIVA_W      = 2,
  parameter int DIVB_W      = 6,
  parameter int PHASE_TICKS = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIVA_W-1:0] divA,
  input  logic [DIVB_W-1:0] divB,
  input  divCmd_t           cmd,
  output divStat_t          stat
);

  localparam int PH_W = $clog2(PHASE_TICKS);
  localparam int HALF = PHASE_TICKS / 2;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASE_TICKS - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF);

  logic [DIVA_W-1:0] cntA;
  logic [DIVB_W-1:0] cntB;
  logic [PH_W-1:0]   phaseCnt;
  logic              aTerm;
  logic              bTerm;
  logic              phaseTerm;

  // First stage: steps on every cycle that is not a clear.
  scl_div_counter #(.W(DIVA_W)) i_stageA (
    .clk   (clk),
    .rstN  (rstN),
    .clear (cmd.clearPre),
    .step  (!cmd.clearPre),
    .limit (divA),
    .cnt   (cntA),
    .term  (aTerm)
  );

  // Second stage: steps on each wrap of the first stage.
  scl_div_counter #(.W(DIVB_W)) i_stageB (
    .clk   (clk),
    .rstN  (rstN),
    .clear (cmd.clearPre),
    .step  (cmd.stepB),
    .limit (divB),
    .cnt   (cntB),
    .term  (bTerm)
  );

  // SCL phase sequencer: fixed modulus, one step per strobe.
  scl_div_counter #(.W(PH_W)) i_phase (
    .clk   (clk),
    .rstN  (rstN),
    .clear (cmd.clearPhase),
    .step  (cmd.stepPhase),
    .limit (PH_LAST),
    .cnt   (phaseCnt),
    .term  (phaseTerm)
  );

  always_comb begin
    stat.aTerm      = aTerm;
    stat.bTerm      = bTerm;
    stat.phaseZero  = (phaseCnt == '0);
    stat.phaseHalf  = (phaseCnt == PH_HALF);
    stat.phaseUpper = (phaseCnt >= PH_HALF);
  end

  // The sequencer wraps only when it is stepped from its last phase.
  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.stepPhase && !cmd.clearPhase && phaseTerm) |=> (phaseCnt == '0)); // R2

endmodule

// File: rtl/scl_div_ctrl.sv
module scl_div_ctrl
  import scl_div_pkg::*;
#(
  parameter int DIVA_W = 2,
  parameter int DIVB_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              engineEn,
  input  logic [DIVA_W-1:0] divA,
  input  logic [DIVB_W-1:0] divB,
  input  divStat_t          stat,
  output divCmd_t           cmd,
  output logic              sampleStrobe,
  output logic              sclOut,
  output logic              sclRiseStb,
  output logic              sclFallStb
);

  logic [DIVA_W-1:0] divAQ;
  logic [DIVB_W-1:0] divBQ;
  logic              fieldChanged;
  logic              strobeQ;

  assign fieldChanged = (divA != divAQ) || (divB != divBQ);

  always_comb begin
    cmd.clearPre   = !engineEn || fieldChanged;
    cmd.stepB      = !cmd.clearPre && stat.aTerm;
    cmd.clearPhase = !engineEn;
    cmd.stepPhase  = engineEn && strobeQ;
  end

  // Stored copy of the fields for change detection.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divAQ <= '0;
      divBQ <= '0;
    end else begin
      divAQ <= divA;
      divBQ <= divB;
    end
  end

  // Registered strobe: both stages at their limits together.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobeQ <= 1'b0;
    end else begin
      strobeQ <= !cmd.clearPre && stat.aTerm && stat.bTerm;
    end
  end

  // SCL level and edge pulses, updated on each strobe tick.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclOut     <= 1'b1;
      sclRiseStb <= 1'b0;
      sclFallStb <= 1'b0;
    end else if (!engineEn) begin
      sclOut     <= 1'b1;
      sclRiseStb <= 1'b0;
      sclFallStb <= 1'b0;
    end else if (strobeQ) begin
      sclOut     <= stat.phaseUpper;
      sclRiseStb <= stat.phaseHalf;
      sclFallStb <= stat.phaseZero;
    end else begin
      sclRiseStb <= 1'b0;
      sclFallStb <= 1'b0;
    end
  end

  assign sampleStrobe = strobeQ;

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && ((divA != '0) || (divB != '0))) |=> !sampleStrobe); // R1

  AST_SCL_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    ($past(engineEn) && !$stable(sclOut)) |-> $past(sampleStrobe)); // R3

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !engineEn |=> (sclOut && !sampleStrobe && !sclRiseStb && !sclFallStb)); // R5

  AST_REWRITE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    fieldChanged |=> !sampleStrobe); // R6

  AST_RISE_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    sclRiseStb |-> (sclOut && !$past(sclOut))); // R7

  AST_FALL_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    sclFallStb |-> (!sclOut && $past(sclOut))); // R7

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(sclRiseStb && sclFallStb)); // R7

endmodule

// File: rtl/scl_clk_gen.sv
module scl_clk_gen
  import scl_div_pkg::*;
#(
  parameter int DIVA_W      = 2,
  parameter int DIVB_W      = 6,
  parameter int PHASE_TICKS = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              engineEn,
  input  logic [DIVA_W-1:0] divA,
  input  logic [DIVB_W-1:0] divB,
  output logic              sampleStrobe,
  output logic              sclOut,
  output logic              sclRiseStb,
  output logic              sclFallStb
);

  divCmd_t  cmd;
  divStat_t stat;

  scl_div_ctrl #(
    .DIVA_W (DIVA_W),
    .DIVB_W (DIVB_W)
  ) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .engineEn     (engineEn),
    .divA         (divA),
    .divB         (divB),
    .stat         (stat),
    .cmd          (cmd),
    .sampleStrobe (sampleStrobe),
    .sclOut       (sclOut),
    .sclRiseStb   (sclRiseStb),
    .sclFallStb   (sclFallStb)
  );

  scl_div_datapath #(
    .DIVA_W      (DIVA_W),
    .DIVB_W      (DIVB_W),
    .PHASE_TICKS (PHASE_TICKS)
  ) i_datapath (
    .clk  (clk),
    .rstN (rstN),
    .divA (divA),
    .divB (divB),
    .cmd  (cmd),
    .stat (stat)
  );

endmodule

// File: tb/test_scl_clk_gen.sv
module test_scl_clk_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       engineEn = 1'b0;
  logic [1:0] divA = '0;
  logic [5:0] divB = '0;
  logic       sampleStrobe;
  logic       sclOut;
  logic       sclRiseStb;
  logic       sclFallStb;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  scl_clk_gen i_scl_clk_gen (
    .clk          (clk),
    .rstN         (rstN),
    .engineEn     (engineEn),
    .divA         (divA),
    .divB         (divB),
    .sampleStrobe (sampleStrobe),
    .sclOut       (sclOut),
    .sclRiseStb   (sclRiseStb),
    .sclFallStb   (sclFallStb)
  );

  always #10 clk = ~clk;

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 180000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<180000", cycles);
      finishRun();
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Cycles until sampleStrobe is seen, counted from the current negedge.
  task automatic waitStrobe(output int cnt);
    cnt = 0;
    do begin
      tick();
      cnt++;
    end while (!sampleStrobe && cnt < 20000);
  endtask

  task automatic sweepPair(int a, int b);
    int n, cnt, per, low, stb, rises, falls;
    logic prev;
    n = (a + 1) * (b + 1);
    engineEn = 1'b0;
    tick();
    divA = 2'(a);
    divB = 6'(b);
    tick();
    tick();
    chk("R5 idle scl", int'(sclOut), 1);
    chk("R5 idle strobe", int'(sampleStrobe), 0);
    engineEn = 1'b1;
    waitStrobe(cnt);
    chk("R4 first strobe latency", cnt, n);
    tick();
    chk("R4 scl falls after first strobe", int'(sclOut), 0);
    // Window runs from this fall cycle up to the next fall cycle.
    per = 1; low = 1; rises = 0;
    falls = int'(sclFallStb);
    stb = int'(sampleStrobe);
    prev = sclOut;
    forever begin
      tick();
      if (!sclOut && prev) break;
      if (per > 30000) break;
      per++;
      if (!sclOut) low++;
      if (sampleStrobe) stb++;
      if (sclRiseStb) rises++;
      if (sclFallStb) falls++;
      if (sclOut && !prev) chk("R7 rise pulse on first high cycle", int'(sclRiseStb), 1);
      prev = sclOut;
    end
    chk("R7 fall pulse on next fall", int'(sclFallStb), 1);
    chk("R2 scl period", per, 22 * n);
    chk("R3 scl low time", low, 11 * n);
    chk("R2 R1 strobes per period", stb, 22);
    chk("R7 one rise pulse", rises, 1);
    chk("R7 one fall pulse", falls, 1);
  endtask

  initial begin
    int cnt, bad;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();
    chk("R5 reset scl", int'(sclOut), 1);
    chk("R5 reset strobe", int'(sampleStrobe), 0);
    chk("R5 reset edge pulses", int'(sclRiseStb | sclFallStb), 0);

    // Sweep every A with a spread of B values.
    for (int a = 0; a < 4; a++) begin
      for (int k = 0; k < 8; k++) begin
        sweepPair(a, (k < 3) ? k : (1 << (k - 1)) - 1);
      end
    end

    // R1: width of a single strobe pulse with N = 2.
    engineEn = 1'b0; tick();
    divA = 2'd1; divB = 6'd0; tick(); tick();
    engineEn = 1'b1;
    waitStrobe(cnt);
    tick();
    chk("R1 strobe single cycle", int'(sampleStrobe), 0);
    tick();
    chk("R1 strobe repeats after N", int'(sampleStrobe), 1);

    // R6: rewrite both fields in mid-run.
    engineEn = 1'b0; tick();
    divA = 2'd1; divB = 6'd2; tick(); tick();
    engineEn = 1'b1;
    repeat (9) tick();
    divA = 2'd2; divB = 6'd1;
    waitStrobe(cnt);
    chk("R6 restart after both fields rewritten", cnt, 7);
    // R6: rewrite only B.
    repeat (2) tick();
    divB = 6'd5;
    waitStrobe(cnt);
    chk("R6 restart after B rewritten", cnt, 19);
    waitStrobe(cnt);
    chk("R6 steady period after rewrite", cnt, 18);

    // R5: disable in the middle of a low phase.
    while (sclOut) tick();
    repeat (3) tick();
    engineEn = 1'b0;
    tick();
    chk("R5 scl high after disable", int'(sclOut), 1);
    chk("R5 strobe low after disable", int'(sampleStrobe), 0);
    bad = 0;
    for (int i = 0; i < 60; i++) begin
      tick();
      if (!sclOut || sampleStrobe || sclRiseStb || sclFallStb) bad++;
    end
    chk("R5 stays idle while disabled", bad, 0);
    // R5: sequencer restarts at low half on re-enable.
    divA = 2'd0; divB = 6'd1; tick(); tick();
    engineEn = 1'b1;
    waitStrobe(cnt);
    tick();
    chk("R5 restart begins with fall", int'(sclFallStb), 1);

    finishRun();
  end

endmodule